// File: doc/BRIEF.md
# Ethernet Transmit Frame Sequencer

This block turns a queue of frame bytes into a nibble-wide line stream for a media-independent transmit interface. Bytes arrive from a byte-wide FIFO-style source. Each byte carries a start-of-frame flag, an end-of-frame flag and a per-frame pad/CRC flag. The block pops a byte only when it needs the next one.

Each frame goes out as preamble, start delimiter, data, optional zero padding and an optional CRC-32 frame check sequence. The transmit enable stays high for the whole frame. Bytes are sent low nibble first, so the bits go out least significant first. An idle gap follows each frame.

When a frame ends, the block reports its length, an oversize flag and an underrun flag with a done pulse. A frame longer than the programmed maximum is flagged and is still sent in full. A graceful stop request halts the transmitter only at a frame boundary and then signals completion.

Top module: `tx_frame_seq`

## Requirements
- R1: After reset, txEn, frameDone, ovPulse, stopDone and inPop are all 0.
- R2: Every frame starts with seven 0x55 bytes and then one 0xD5 byte. Each byte appears on txd as the low nibble and then the high nibble, one nibble per clock. txEn stays high from the first preamble nibble to the last nibble of the frame.
- R3: Data bytes go out in queue order, one byte every two clocks, starting with the byte flagged start-of-frame.
- R4: The pad/CRC flag is read from the byte flagged end-of-frame. When it is 1, a frame with fewer than 60 data bytes gets 0x00 bytes up to 60. Four check bytes follow. They are the bitwise inverse of a CRC-32 register that starts at all ones and is updated LSB first with the reflected polynomial 0xEDB88320 over data and padding. The low byte of the result is sent first.
- R5: When the pad/CRC flag is 0, no padding and no check bytes are sent. The frame ends after its last data byte.
- R6: When a frame completes, frameDone pulses for one cycle in the same cycle that txEn falls. statLen then holds the number of bytes sent after the 0xD5 byte, counting padding and check bytes.
- R7: When statLen exceeds maxLen, statOversize is 1 and ovPulse pulses together with frameDone. The frame is still sent in full.
- R8: If the queue is empty when the next data byte of a frame is due, txEn drops at once and statUnderrun is 1 at the done pulse. statLen then counts only the data bytes sent.
- R9: A stop request while idle raises stopDone within a few cycles. No frame starts while the request stays high.
- R10: A stop request raised during a frame lets that frame finish in full. stopDone pulses only after the frame's done pulse. Clearing the request resumes transmission with the next queued frame.
- R11: Between txEn falling and rising again there are at least 24 clocks (12 byte times).
- R12: While idle, queued bytes without the start-of-frame flag are popped and discarded, and nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Byte at the head of the queue |
| inValid | input | 1 | Queue not empty |
| inSof | input | 1 | Head byte starts a frame |
| inEof | input | 1 | Head byte ends a frame |
| inPadCrc | input | 1 | Pad/CRC request, read with the end-of-frame byte |
| inPop | output | 1 | Head byte consumed at this clock edge |
| maxLen | input | LEN_W | Maximum frame length before flagging oversize |
| stopReq | input | 1 | Graceful stop request |
| txd | output | 4 | Transmit nibble |
| txEn | output | 1 | Transmit enable |
| frameDone | output | 1 | One-cycle pulse when a frame ends |
| statLen | output | LEN_W | Length of the last frame after the delimiter |
| statOversize | output | 1 | Last frame exceeded maxLen |
| statUnderrun | output | 1 | Last frame was cut off by an empty queue |
| ovPulse | output | 1 | One-cycle pulse for an oversize frame |
| stopDone | output | 1 | One-cycle pulse when the transmitter has stopped |

## Verification
The bench sweeps padded frames of 1 to 70 data bytes with maxLen at 64, so it crosses both the 60-byte padding edge and the oversize edge. A design off by one there would pad a 60-byte frame, leave a 59-byte frame short, or flag a 64-byte frame. It also checks the received check bytes against a CRC computed bit by bit in the bench, which catches a wrong byte order or a check word that is not inverted. Unpadded frames, an underrun in mid-frame, stray bytes while idle, and stop requests both while idle and during a frame are also covered. These expose a design that pads when told not to, keeps txEn high after running dry, starts a frame from a stray byte, or cuts off or reports too early the frame that was in flight. Back-to-back frames check the idle gap.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [2:0] {
    SRC_PRE,
    SRC_SFD,
    SRC_DATA,
    SRC_PAD,
    SRC_FCS
  } byteSrc_t;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic      hi;       // second half of a byte slot
    logic      load;     // start a new byte slot
    byteSrc_t  src;      // where the new byte comes from
    logic [1:0] fcsIdx;  // which check byte
    logic      crcInit;
    logic      crcUpd;
    logic      lenClr;
    logic      lenInc;
  } txStrobe_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? CRC_POLY_REFL : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/tx_seq_datapath.sv
module tx_seq_datapath
  import tx_seq_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        str,
  input  logic [7:0]       inData,
  output logic [LEN_W-1:0] lenCnt,
  output logic [3:0]       txd,
  output logic             txEn
);

  logic [7:0]  byteReg;
  logic [7:0]  selByte;
  logic [7:0]  fcsByte;
  logic [31:0] crcReg;

  always_comb begin
    case (str.fcsIdx)
      2'd0:    fcsByte = ~crcReg[7:0];
      2'd1:    fcsByte = ~crcReg[15:8];
      2'd2:    fcsByte = ~crcReg[23:16];
      default: fcsByte = ~crcReg[31:24];
    endcase
  end

  always_comb begin
    case (str.src)
      SRC_PRE:  selByte = 8'h55;
      SRC_SFD:  selByte = 8'hD5;
      SRC_DATA: selByte = inData;
      SRC_PAD:  selByte = 8'h00;
      SRC_FCS:  selByte = fcsByte;
      default:  selByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteReg <= '0;
      txd     <= '0;
      txEn    <= 1'b0;
      crcReg  <= '1;
      lenCnt  <= '0;
    end else begin
      if (str.hi) begin
        txd <= txEn ? byteReg[7:4] : 4'h0;
      end else if (str.load) begin
        byteReg <= selByte;
        txd     <= selByte[3:0];
        txEn    <= 1'b1;
      end else begin
        txd  <= 4'h0;
        txEn <= 1'b0;
      end

      if (str.crcInit)     crcReg <= '1;
      else if (str.crcUpd) crcReg <= crcByte(crcReg, selByte);

      if (str.lenClr)      lenCnt <= '0;
      else if (str.lenInc) lenCnt <= lenCnt + 1'b1;
    end
  end

  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.hi |=> $stable(txEn));

  // R4
  fcs_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.load && str.src == SRC_FCS) |=> $stable(crcReg));

endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl
  import tx_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 60,
  parameter int IFG_BYTES = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             inPadCrc,
  output logic             inPop,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             stopReq,
  input  logic [LEN_W-1:0] lenCnt,
  output txStrobe_t        str,
  output logic             frameDone,
  output logic [LEN_W-1:0] statLen,
  output logic             statOversize,
  output logic             statUnderrun,
  output logic             ovPulse,
  output logic             stopDone
);

  localparam int CNT_MAX0 = (PRE_BYTES > IFG_BYTES) ? PRE_BYTES : IFG_BYTES;
  localparam int CNT_MAX  = (CNT_MAX0 > 4) ? CNT_MAX0 : 4;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_BYTES);
  localparam logic [CNT_W-1:0] IFG_LAST = CNT_W'(IFG_BYTES - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(3);
  localparam logic [LEN_W:0]   MIN_LEN  = (LEN_W+1)'(MIN_DATA);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_DATA, ST_PAD, ST_FCS, ST_IFG, ST_STOP
  } state_t;

  state_t           state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             phase, act;
  logic             padLatch, padNx;
  logic             urLatch, urNx;
  logic             statStrobe, stopEnter;
  logic [LEN_W:0]   lenNext;

  assign act     = (state != ST_IDLE) && (state != ST_STOP);
  assign lenNext = {1'b0, lenCnt} + 1'b1;

  always_comb begin
    stateNx    = state;
    cntNx      = cnt;
    padNx      = padLatch;
    urNx       = urLatch;
    str        = '0;
    str.hi     = phase && act;
    inPop      = 1'b0;
    statStrobe = 1'b0;
    stopEnter  = 1'b0;
    if (!phase) begin
      case (state)
        ST_IDLE: begin
          if (stopReq) begin
            stateNx   = ST_STOP;
            stopEnter = 1'b1;
          end else if (inValid && inSof) begin
            stateNx = ST_PRE;
            cntNx   = '0;
            padNx   = 1'b0;
            urNx    = 1'b0;
          end else if (inValid) begin
            inPop = 1'b1;
          end
        end
        ST_PRE: begin
          str.load = 1'b1;
          str.src  = (cnt == PRE_LAST) ? SRC_SFD : SRC_PRE;
          cntNx    = cnt + 1'b1;
          if (cnt == PRE_LAST) begin
            str.crcInit = 1'b1;
            str.lenClr  = 1'b1;
            stateNx     = ST_DATA;
          end
        end
        ST_DATA: begin
          if (inValid) begin
            inPop      = 1'b1;
            str.load   = 1'b1;
            str.src    = SRC_DATA;
            str.crcUpd = 1'b1;
            str.lenInc = 1'b1;
            if (inEof) begin
              padNx = inPadCrc;
              cntNx = '0;
              if (!inPadCrc)              stateNx = ST_IFG;
              else if (lenNext >= MIN_LEN) stateNx = ST_FCS;
              else                        stateNx = ST_PAD;
            end
          end else begin
            urNx    = 1'b1;
            cntNx   = '0;
            stateNx = ST_IFG;
          end
        end
        ST_PAD: begin
          str.load   = 1'b1;
          str.src    = SRC_PAD;
          str.crcUpd = 1'b1;
          str.lenInc = 1'b1;
          if (lenNext >= MIN_LEN) begin
            stateNx = ST_FCS;
            cntNx   = '0;
          end
        end
        ST_FCS: begin
          str.load   = 1'b1;
          str.src    = SRC_FCS;
          str.fcsIdx = cnt[1:0];
          str.lenInc = 1'b1;
          cntNx      = cnt + 1'b1;
          if (cnt == FCS_LAST) begin
            stateNx = ST_IFG;
            cntNx   = '0;
          end
        end
        ST_IFG: begin
          statStrobe = (cnt == '0);
          cntNx      = cnt + 1'b1;
          if (cnt == IFG_LAST) stateNx = ST_IDLE;
        end
        ST_STOP: begin
          if (!stopReq) stateNx = ST_IDLE;
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      phase        <= 1'b0;
      padLatch     <= 1'b0;
      urLatch      <= 1'b0;
      frameDone    <= 1'b0;
      statLen      <= '0;
      statOversize <= 1'b0;
      statUnderrun <= 1'b0;
      ovPulse      <= 1'b0;
      stopDone     <= 1'b0;
    end else begin
      state     <= stateNx;
      cnt       <= cntNx;
      phase     <= act ? ~phase : 1'b0;
      padLatch  <= padNx;
      urLatch   <= urNx;
      frameDone <= statStrobe;
      ovPulse   <= statStrobe && (lenCnt > maxLen);
      stopDone  <= stopEnter;
      if (statStrobe) begin
        statLen      <= lenCnt;
        statOversize <= lenCnt > maxLen;
        statUnderrun <= urLatch;
      end
    end
  end

  // R9
  stop_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |-> (state == ST_STOP));

  // R4
  pad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && padLatch && !statUnderrun) |-> (statLen >= LEN_W'(MIN_DATA + 4)));

  // R12
  no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE || state == ST_PAD || state == ST_FCS) |-> !inPop);

  // R7
  ov_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovPulse |-> (frameDone && statOversize));

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_seq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PRE_BYTES = 7,
  parameter int MIN_DATA  = 60,
  parameter int IFG_BYTES = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic             inPadCrc,
  output logic             inPop,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             stopReq,
  output logic [3:0]       txd,
  output logic             txEn,
  output logic             frameDone,
  output logic [LEN_W-1:0] statLen,
  output logic             statOversize,
  output logic             statUnderrun,
  output logic             ovPulse,
  output logic             stopDone
);

  txStrobe_t        str;
  logic [LEN_W-1:0] lenCnt;

  tx_seq_ctrl #(
    .LEN_W(LEN_W), .PRE_BYTES(PRE_BYTES), .MIN_DATA(MIN_DATA), .IFG_BYTES(IFG_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSof(inSof), .inEof(inEof), .inPadCrc(inPadCrc), .inPop(inPop),
    .maxLen(maxLen), .stopReq(stopReq), .lenCnt(lenCnt), .str(str),
    .frameDone(frameDone), .statLen(statLen), .statOversize(statOversize),
    .statUnderrun(statUnderrun), .ovPulse(ovPulse), .stopDone(stopDone)
  );

  tx_seq_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .inData(inData),
    .lenCnt(lenCnt), .txd(txd), .txEn(txEn)
  );

endmodule

// File: tb/sim_tx_frame_seq.sv
`timescale 1ns/1ps
module sim_tx_frame_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData;
  logic        inValid, inSof, inEof, inPadCrc, inPop;
  logic [15:0] maxLen = 16'd64;
  logic        stopReq = 1'b0;
  logic [3:0]  txd;
  logic        txEn, frameDone, statOversize, statUnderrun, ovPulse, stopDone;
  logic [15:0] statLen;

  always #5 clk = ~clk;

  // byte queue model: {sof, eof, padCrc, data}
  logic [10:0] fifoMem [0:1023];
  logic [31:0] wrPtr = 0, rdPtr = 0;
  logic [10:0] head;
  assign head    = fifoMem[rdPtr[9:0]];
  assign inValid = (rdPtr != wrPtr);
  assign {inSof, inEof, inPadCrc, inData} = head;
  always @(posedge clk) if (inPop) rdPtr <= rdPtr + 1;

  tx_frame_seq u0 (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inSof(inSof),
    .inEof(inEof), .inPadCrc(inPadCrc), .inPop(inPop), .maxLen(maxLen),
    .stopReq(stopReq), .txd(txd), .txEn(txEn), .frameDone(frameDone),
    .statLen(statLen), .statOversize(statOversize), .statUnderrun(statUnderrun),
    .ovPulse(ovPulse), .stopDone(stopDone)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // line monitor, samples at negedge
  logic [7:0] rxBuf [0:255];
  int   rxCnt = 0, gapCnt = 0, lastGap = 0, riseCnt = 0, doneCnt = 0, ovCnt = 0, stopCnt = 0;
  int   doneCyc = 0, stopCyc = 0;
  logic nib = 1'b0, prevEn = 1'b0, doneAtFall = 1'b0, doneOv = 1'b0, doneUr = 1'b0;
  logic [3:0]  lowNib = 4'h0;
  logic [15:0] doneLen = 0;

  always @(negedge clk) begin
    if (txEn) begin
      if (!prevEn) begin
        riseCnt <= riseCnt + 1;
        lastGap <= gapCnt;
        rxCnt   <= 0;
        lowNib  <= txd;
        nib     <= 1'b1;
      end else if (!nib) begin
        lowNib <= txd;
        nib    <= 1'b1;
      end else begin
        rxBuf[rxCnt[7:0]] <= {txd, lowNib};
        rxCnt <= rxCnt + 1;
        nib   <= 1'b0;
      end
      gapCnt <= 0;
    end else begin
      nib    <= 1'b0;
      gapCnt <= gapCnt + 1;
    end
    prevEn <= txEn;
    if (frameDone) begin
      doneCnt    <= doneCnt + 1;
      doneCyc    <= cyc;
      doneLen    <= statLen;
      doneOv     <= statOversize;
      doneUr     <= statUnderrun;
      doneAtFall <= prevEn && !txEn;
    end
    if (ovPulse)  ovCnt <= ovCnt + 1;
    if (stopDone) begin
      stopCnt <= stopCnt + 1;
      stopCyc <= cyc;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 7 + i * 13 + 5);
  endfunction

  task automatic pushByte(input logic [7:0] d, input bit sof, input bit eof, input bit pad);
    fifoMem[wrPtr[9:0]] = {sof, eof, pad, d};
    wrPtr = wrPtr + 1;
  endtask

  task automatic pushFrame(input int len, input bit pad, input int seed, input bit withEof);
    @(negedge clk);
    for (int i = 0; i < len; i++)
      pushByte(pat(seed, i), i == 0, withEof && (i == len - 1), pad);
  endtask

  task automatic waitDone(input string tag);
    int d0 = doneCnt;
    int n = 0;
    while (doneCnt == d0 && n < 3000) begin
      @(posedge clk);
      n++;
    end
    chk(doneCnt != d0, {tag, " done timeout"}, n, 0);
  endtask

  task automatic checkFrame(input int len, input bit pad, input int seed, input int ov0);
    int padLen = (pad && len < 60) ? 60 : len;
    int fcsN = pad ? 4 : 0;
    int expLen = padLen + fcsN;
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0] b;
    int firstBad = -1;
    bit expOv = (expLen > maxLen);
    bit preOk = 1'b1;
    bit padOk = 1'b1;
    bit fcsOk = 1'b1;
    for (int i = 0; i < 7; i++) if (rxBuf[i] != 8'h55) preOk = 1'b0;
    if (rxBuf[7] != 8'hD5) preOk = 1'b0;
    chk(preOk, "R2 preamble/SFD", rxBuf[7], 8'hD5);
    chk(rxCnt == 8 + expLen, pad ? "R4 wire length" : "R5 wire length", rxCnt, 8 + expLen);
    for (int i = 0; i < len; i++) if (firstBad < 0 && rxBuf[8 + i] != pat(seed, i)) firstBad = i;
    chk(firstBad < 0, "R3 data order", firstBad, -1);
    for (int i = len; i < padLen; i++) if (rxBuf[8 + i] != 8'h00) padOk = 1'b0;
    chk(padOk, "R4 pad bytes zero", len, padLen);
    if (pad) begin
      for (int i = 0; i < padLen; i++) begin
        b = (i < len) ? pat(seed, i) : 8'h00;
        c = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      c = ~c;
      for (int k = 0; k < 4; k++) if (rxBuf[8 + padLen + k] != c[8*k +: 8]) fcsOk = 1'b0;
      chk(fcsOk, "R4 fcs", rxBuf[8 + padLen], c[7:0]);
    end
    chk(doneLen == expLen, "R6 statLen", doneLen, expLen);
    chk(doneAtFall, "R6 done at txEn fall", doneAtFall, 1);
    chk(doneOv == expOv && (ovCnt - ov0) == int'(expOv), "R7 oversize flag", doneOv, expOv);
  endtask

  initial begin
    int r0, s0, ov0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!txEn && !frameDone && !ovPulse && !stopDone && !inPop, "R1 reset outputs", txEn, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!txEn && !inPop, "R1 idle after reset", txEn, 0);

    // sweep padded frames across padding and oversize edges (R4, R7)
    for (int len = 1; len <= 70; len++) begin
      ov0 = ovCnt;
      pushFrame(len, 1'b1, len, 1'b1);
      waitDone("R4 sweep");
      @(posedge clk);
      checkFrame(len, 1'b1, len, ov0);
    end

    // sweep unpadded frames (R5)
    for (int len = 1; len <= 20; len++) begin
      ov0 = ovCnt;
      pushFrame(len, 1'b0, len + 100, 1'b1);
      waitDone("R5 sweep");
      @(posedge clk);
      checkFrame(len, 1'b0, len + 100, ov0);
    end

    // long oversize frame still sent whole (R7)
    maxLen = 16'd70;
    ov0 = ovCnt;
    pushFrame(90, 1'b1, 3, 1'b1);
    waitDone("R7 long");
    @(posedge clk);
    checkFrame(90, 1'b1, 3, ov0);
    maxLen = 16'd64;

    // underrun in mid-frame (R8)
    pushFrame(5, 1'b1, 9, 1'b0);
    waitDone("R8");
    @(posedge clk);
    chk(doneUr == 1'b1, "R8 underrun flag", doneUr, 1);
    chk(doneLen == 5, "R8 statLen", doneLen, 5);
    chk(rxCnt == 13, "R8 wire bytes", rxCnt, 13);
    repeat (40) @(posedge clk);

    // stray bytes while idle (R12)
    r0 = riseCnt;
    @(negedge clk);
    pushByte(8'hA1, 0, 0, 1);
    pushByte(8'hA2, 0, 1, 1);
    pushByte(8'hA3, 0, 0, 0);
    repeat (20) @(posedge clk);
    chk(rdPtr == wrPtr, "R12 stray bytes popped", rdPtr, wrPtr);
    chk(riseCnt == r0, "R12 nothing sent", riseCnt, r0);
    ov0 = ovCnt;
    pushFrame(12, 1'b1, 44, 1'b1);
    waitDone("R12 after");
    @(posedge clk);
    checkFrame(12, 1'b1, 44, ov0);
    repeat (40) @(posedge clk);

    // graceful stop while idle (R9)
    s0 = stopCnt;
    r0 = riseCnt;
    @(negedge clk);
    stopReq = 1'b1;
    repeat (5) @(posedge clk);
    chk(stopCnt == s0 + 1, "R9 stop done while idle", stopCnt, s0 + 1);
    pushFrame(20, 1'b1, 55, 1'b1);
    repeat (300) @(posedge clk);
    chk(riseCnt == r0, "R9 no frame while stopped", riseCnt, r0);
    @(negedge clk);
    stopReq = 1'b0;
    ov0 = ovCnt;
    waitDone("R10 resume");
    @(posedge clk);
    checkFrame(20, 1'b1, 55, ov0);
    repeat (40) @(posedge clk);

    // graceful stop during a frame (R10)
    s0 = stopCnt;
    ov0 = ovCnt;
    pushFrame(30, 1'b1, 66, 1'b1);
    while (!txEn) @(negedge clk);
    stopReq = 1'b1;
    pushFrame(12, 1'b1, 77, 1'b1);
    waitDone("R10 inflight");
    @(posedge clk);
    checkFrame(30, 1'b1, 66, ov0);
    r0 = riseCnt;
    repeat (60) @(posedge clk);
    chk(stopCnt == s0 + 1, "R10 stop done after frame", stopCnt, s0 + 1);
    chk(stopCyc > doneCyc, "R10 stop after done", stopCyc, doneCyc);
    repeat (200) @(posedge clk);
    chk(riseCnt == r0, "R10 held while stopped", riseCnt, r0);
    @(negedge clk);
    stopReq = 1'b0;
    ov0 = ovCnt;
    waitDone("R10 next");
    @(posedge clk);
    checkFrame(12, 1'b1, 77, ov0);
    repeat (40) @(posedge clk);

    // back-to-back idle gap (R11)
    pushFrame(10, 1'b1, 88, 1'b1);
    pushFrame(10, 1'b1, 99, 1'b1);
    waitDone("R11 first");
    ov0 = ovCnt;
    waitDone("R11 second");
    @(posedge clk);
    chk(lastGap >= 24, "R11 idle gap", lastGap, 24);
    checkFrame(10, 1'b1, 99, ov0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule